// File: doc/BRIEF.md
# Programmable Video Line Region Timer

This block keeps the horizontal and vertical position for a progressive video format. It also marks where the active and blanking regions fall inside each line and each frame. A pixel enable moves a pixel counter along the line. When the line ends, a line counter steps and wraps at the end of the frame. From these two counts the block drives four outputs: a one-pixel start-of-active-video (SAV) strobe, an end-of-active-video (EAV) strobe, a vertical blanking (VBI) flag and an active-video flag.

The timing registers set the line length, the number of lines per frame, and the SAV, EAV, VBI start and VBI end positions. When a position register holds zero, the block uses a value derived from the format. This lets software program only the line length and frame height for common formats. The block samples every timing register once, at the start of each frame.

The block also holds the last measured horizontal sync trailing-edge position. It can keep that value frozen while inside VBI. With embedded sync that carries serration pulses, the edges seen during blanking are not valid, and freezing stops them from corrupting the estimate. This design has no streaming data path: all pins are plain control and status levels, so no back-pressure rules apply.

Top module: `vid_region_timer`

## Requirements
- R1: While reset is held and in the first cycle after it, pix_idx is 0, line_idx is 1, hs_trail_pos is 0, and neither strobe fires.
- R2: pix_idx advances by one only in a cycle with pix_en high, and wraps from line_len-1 to 0. At that wrap line_idx steps by one, going from frame_lines back to 1.
- R3: SAV position is sav_cfg when nonzero. When sav_cfg is zero, it is floor(3*line_len/16), which gives 309 for a 1650-pixel line. sav_strobe is high only in a pix_en cycle whose pix_idx equals that position.
- R4: EAV position is eav_cfg when nonzero, so 0x5DC gives 1500. When eav_cfg is zero, it is line_len - floor(line_len/16). eav_strobe is high only in a pix_en cycle at that position.
- R5: VBI start line is vbi_start_cfg when nonzero. When vbi_start_cfg is zero, it is frame_lines - 5, which gives 745 for a 750-line frame.
- R6: VBI end line is vbi_end_cfg when nonzero. When vbi_end_cfg is zero, it is line 4.
- R7: vbi is high on the lines from the start line through the end line, inclusive. When the start line is greater than the end line, the region wraps: it runs from the start line to frame_lines and then from line 1 to the end line.
- R8: active is high exactly when vbi is low, pix_idx is at or after the SAV position, and pix_idx is before the EAV position.
- R9: All six timing registers are captured at the first cycle after reset and at every frame wrap. A change made mid-frame takes effect only from the next frame.
- R10: If freeze_en is high and vbi is high, a hs_edge_valid pulse leaves hs_trail_pos unchanged. freeze_en is used live and is not captured per frame.
- R11: If hs_edge_valid is high while vbi is low, or while freeze_en is low, hs_trail_pos takes hs_edge_pos on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel advance enable |
| line_len | input | 12 | Pixels per line |
| frame_lines | input | 11 | Lines per frame |
| sav_cfg | input | 12 | SAV pixel, 0 = derived |
| eav_cfg | input | 12 | EAV pixel, 0 = derived |
| vbi_start_cfg | input | 11 | First blanking line, 0 = derived |
| vbi_end_cfg | input | 11 | Last blanking line, 0 = derived |
| freeze_en | input | 1 | Hold sync-edge tracking during VBI |
| hs_edge_valid | input | 1 | A new trailing-edge measurement is present |
| hs_edge_pos | input | 12 | Measured trailing-edge pixel |
| pix_idx | output | 12 | Current pixel index |
| line_idx | output | 11 | Current line number |
| sav_strobe | output | 1 | SAV pixel pulse |
| eav_strobe | output | 1 | EAV pixel pulse |
| vbi | output | 1 | Vertical blanking flag |
| active | output | 1 | Active-video flag |
| hs_trail_pos | output | 12 | Tracked trailing-edge position |

## Verification
The main function is tested with four patterns:
- **Small frame, every position register zero.** Shows the derived SAV, EAV and blanking values, and a VBI region that wraps across the frame boundary.
- **Explicit, non-wrapping settings.** Separates the direct-value path from the derived one, and separates inclusive from wrapped VBI decoding.
- **The 1650-pixel, 750-line format.** Checks the derived SAV of 309 and the direct EAV of 1500 at full width.
- **A mid-frame register write.** Shows whether the new value is held back until the next frame.

The tracker is pulsed inside and outside blanking, with freeze enabled and with it disabled. This tells a correct freeze apart from a freeze that ignores the VBI flag and from one that ignores the enable.

// File: rtl/vrt_pkg.sv
package vrt_pkg;
  localparam int SAV_MUL        = 3;
  localparam int SAV_SHIFT      = 4;
  localparam int EAV_SHIFT      = 4;
  localparam int VBI_START_BACK = 5;
  localparam int VBI_END_AUTO   = 4;
endpackage

// File: rtl/vrt_cfg_shadow.sv
module vrt_cfg_shadow #(
  parameter int CW = 12,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] line_len,
  input  logic [LW-1:0] frame_lines,
  input  logic [CW-1:0] sav_cfg,
  input  logic [CW-1:0] eav_cfg,
  input  logic [LW-1:0] vs_cfg,
  input  logic [LW-1:0] ve_cfg,
  output logic [CW-1:0] len_q,
  output logic [LW-1:0] lines_q,
  output logic [CW-1:0] sav_pos,
  output logic [CW-1:0] eav_pos,
  output logic [LW-1:0] vs_line,
  output logic [LW-1:0] ve_line
);
  import vrt_pkg::*;
  localparam int XW = CW + 2;

  logic [CW-1:0] sav_q, eav_q;
  logic [LW-1:0] vs_q, ve_q;
  logic [XW-1:0] len_mul, sav_auto_w;
  logic [CW-1:0] eav_auto;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q   <= '0;
      lines_q <= '0;
      sav_q   <= '0;
      eav_q   <= '0;
      vs_q    <= '0;
      ve_q    <= '0;
    end else if (load) begin
      len_q   <= line_len;
      lines_q <= frame_lines;
      sav_q   <= sav_cfg;
      eav_q   <= eav_cfg;
      vs_q    <= vs_cfg;
      ve_q    <= ve_cfg;
    end
  end

  assign len_mul    = XW'(len_q) * XW'(SAV_MUL);
  assign sav_auto_w = len_mul >> SAV_SHIFT;
  assign eav_auto   = len_q - (len_q >> EAV_SHIFT);

  assign sav_pos = (sav_q != '0) ? sav_q : sav_auto_w[CW-1:0];
  assign eav_pos = (eav_q != '0) ? eav_q : eav_auto;
  assign vs_line = (vs_q != '0) ? vs_q : (lines_q - LW'(VBI_START_BACK));
  assign ve_line = (ve_q != '0) ? ve_q : LW'(VBI_END_AUTO);
endmodule

// File: rtl/vrt_counter.sv
module vrt_counter #(
  parameter int CW = 12,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [CW-1:0] len_q,
  input  logic [LW-1:0] lines_q,
  output logic [CW-1:0] pix,
  output logic [LW-1:0] line,
  output logic          frame_end
);
  logic line_end;

  assign line_end  = step && (pix == len_q - CW'(1));
  assign frame_end = line_end && (line == lines_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix  <= '0;
      line <= LW'(1);
    end else if (step) begin
      if (line_end) begin
        pix  <= '0;
        line <= frame_end ? LW'(1) : line + LW'(1);
      end else begin
        pix <= pix + CW'(1);
      end
    end
  end
endmodule

// File: rtl/vrt_region_decode.sv
module vrt_region_decode #(
  parameter int CW = 12,
  parameter int LW = 11
) (
  input  logic          step,
  input  logic [CW-1:0] pix,
  input  logic [LW-1:0] line,
  input  logic [CW-1:0] sav_pos,
  input  logic [CW-1:0] eav_pos,
  input  logic [LW-1:0] vs_line,
  input  logic [LW-1:0] ve_line,
  output logic          sav_strobe,
  output logic          eav_strobe,
  output logic          vbi,
  output logic          active
);
  always_comb begin
    if (vs_line <= ve_line)
      vbi = (line >= vs_line) && (line <= ve_line);
    else
      vbi = (line >= vs_line) || (line <= ve_line);
  end

  assign active     = !vbi && (pix >= sav_pos) && (pix < eav_pos);
  assign sav_strobe = step && (pix == sav_pos);
  assign eav_strobe = step && (pix == eav_pos);
endmodule

// File: rtl/vrt_hs_track.sv
module vrt_hs_track #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          freeze_en,
  input  logic          in_vbi,
  input  logic          edge_valid,
  input  logic [CW-1:0] edge_pos,
  output logic [CW-1:0] trail_pos
);
  logic hold;

  assign hold = freeze_en && in_vbi;

  always_ff @(posedge clk) begin
    if (!rst_n)                  trail_pos <= '0;
    else if (edge_valid && !hold) trail_pos <= edge_pos;
  end
endmodule

// File: rtl/vid_region_timer.sv
module vid_region_timer #(
  parameter int CW = 12,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic [CW-1:0] line_len,
  input  logic [LW-1:0] frame_lines,
  input  logic [CW-1:0] sav_cfg,
  input  logic [CW-1:0] eav_cfg,
  input  logic [LW-1:0] vbi_start_cfg,
  input  logic [LW-1:0] vbi_end_cfg,
  input  logic          freeze_en,
  input  logic          hs_edge_valid,
  input  logic [CW-1:0] hs_edge_pos,
  output logic [CW-1:0] pix_idx,
  output logic [LW-1:0] line_idx,
  output logic          sav_strobe,
  output logic          eav_strobe,
  output logic          vbi,
  output logic          active,
  output logic [CW-1:0] hs_trail_pos
);
  logic          run, step, frame_end, load;
  logic [CW-1:0] len_q, sav_pos, eav_pos;
  logic [LW-1:0] lines_q, vs_line, ve_line;

  always_ff @(posedge clk) begin
    if (!rst_n) run <= 1'b0;
    else        run <= 1'b1;
  end

  assign step = run && pix_en;
  assign load = !run || frame_end;

  vrt_cfg_shadow #(.CW(CW), .LW(LW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load),
    .line_len(line_len), .frame_lines(frame_lines),
    .sav_cfg(sav_cfg), .eav_cfg(eav_cfg),
    .vs_cfg(vbi_start_cfg), .ve_cfg(vbi_end_cfg),
    .len_q(len_q), .lines_q(lines_q),
    .sav_pos(sav_pos), .eav_pos(eav_pos),
    .vs_line(vs_line), .ve_line(ve_line)
  );

  vrt_counter #(.CW(CW), .LW(LW)) u_count (
    .clk(clk), .rst_n(rst_n), .step(step),
    .len_q(len_q), .lines_q(lines_q),
    .pix(pix_idx), .line(line_idx), .frame_end(frame_end)
  );

  vrt_region_decode #(.CW(CW), .LW(LW)) u_decode (
    .step(step), .pix(pix_idx), .line(line_idx),
    .sav_pos(sav_pos), .eav_pos(eav_pos),
    .vs_line(vs_line), .ve_line(ve_line),
    .sav_strobe(sav_strobe), .eav_strobe(eav_strobe),
    .vbi(vbi), .active(active)
  );

  vrt_hs_track #(.CW(CW)) u_hs (
    .clk(clk), .rst_n(rst_n), .freeze_en(freeze_en), .in_vbi(vbi),
    .edge_valid(hs_edge_valid), .edge_pos(hs_edge_pos),
    .trail_pos(hs_trail_pos)
  );
endmodule

// File: rtl/vid_region_timer_checker.sv
module vid_region_timer_checker #(
  parameter int CW = 12,
  parameter int LW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_en,
  input logic          freeze_en,
  input logic          hs_edge_valid,
  input logic [CW-1:0] hs_edge_pos,
  input logic [CW-1:0] pix_idx,
  input logic [LW-1:0] line_idx,
  input logic          sav_strobe,
  input logic          eav_strobe,
  input logic          vbi,
  input logic          active,
  input logic [CW-1:0] hs_trail_pos
);
  assert_hold_without_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(pix_idx) && $stable(line_idx)));

  assert_line_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_idx != '0);

  assert_sav_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sav_strobe |-> pix_en);

  assert_eav_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eav_strobe |-> pix_en);

  assert_active_outside_vbi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !vbi);

  assert_freeze_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_edge_valid && freeze_en && vbi) |=> $stable(hs_trail_pos));

  assert_track_updates_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_edge_valid && !vbi) |=> (hs_trail_pos == $past(hs_edge_pos)));
endmodule

bind vid_region_timer vid_region_timer_checker #(.CW(CW), .LW(LW)) u_checker (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .freeze_en(freeze_en),
  .hs_edge_valid(hs_edge_valid), .hs_edge_pos(hs_edge_pos),
  .pix_idx(pix_idx), .line_idx(line_idx), .sav_strobe(sav_strobe),
  .eav_strobe(eav_strobe), .vbi(vbi), .active(active),
  .hs_trail_pos(hs_trail_pos)
);

// File: tb/vid_region_timer_bench.sv
module vid_region_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int LW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pix_en = 1'b0;
  logic [CW-1:0] line_len = '0;
  logic [LW-1:0] frame_lines = '0;
  logic [CW-1:0] sav_cfg = '0, eav_cfg = '0;
  logic [LW-1:0] vbi_start_cfg = '0, vbi_end_cfg = '0;
  logic          freeze_en = 1'b0, hs_edge_valid = 1'b0;
  logic [CW-1:0] hs_edge_pos = '0;
  logic [CW-1:0] pix_idx, hs_trail_pos;
  logic [LW-1:0] line_idx;
  logic          sav_strobe, eav_strobe, vbi, active;

  int n_checks = 0;
  int n_fails  = 0;
  int mp = 0;
  int ml = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_region_timer #(.CW(CW), .LW(LW)) u_vid_region_timer (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_len(line_len),
    .frame_lines(frame_lines), .sav_cfg(sav_cfg), .eav_cfg(eav_cfg),
    .vbi_start_cfg(vbi_start_cfg), .vbi_end_cfg(vbi_end_cfg),
    .freeze_en(freeze_en), .hs_edge_valid(hs_edge_valid),
    .hs_edge_pos(hs_edge_pos), .pix_idx(pix_idx), .line_idx(line_idx),
    .sav_strobe(sav_strobe), .eav_strobe(eav_strobe), .vbi(vbi),
    .active(active), .hs_trail_pos(hs_trail_pos)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d (line %0d pix %0d)", req, what, act, exp, ml, mp);
    end
  endtask

  function automatic bit exp_vbi(input int line, input int vs, input int ve);
    if (vs <= ve) return (line >= vs) && (line <= ve);
    return (line >= vs) || (line <= ve);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pix_en = 1'b0; hs_edge_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "pix_idx after reset", int'(pix_idx), 0);
    check("R1", "line_idx after reset", int'(line_idx), 1);
    check("R1", "hs_trail_pos after reset", int'(hs_trail_pos), 0);
    check("R1", "strobes after reset", int'(sav_strobe) + int'(eav_strobe), 0);
    @(posedge clk);
    mp = 0; ml = 1;
  endtask

  // advance n pixels, checking every output at each position against the model
  task automatic walk(input int n, input int len, input int lines, input int sp,
                      input int ep, input int vs, input int ve);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      pix_en = 1'b1;
      #1;
      check("R2", "pix_idx", int'(pix_idx), mp);
      check("R2", "line_idx", int'(line_idx), ml);
      check("R3", "sav_strobe", int'(sav_strobe), int'(mp == sp));
      check("R4", "eav_strobe", int'(eav_strobe), int'(mp == ep));
      check("R7", "vbi", int'(vbi), int'(exp_vbi(ml, vs, ve)));
      check("R8", "active", int'(active),
            int'(!exp_vbi(ml, vs, ve) && mp >= sp && mp < ep));
      @(posedge clk);
      if (mp == len - 1) begin
        mp = 0;
        ml = (ml == lines) ? 1 : ml + 1;
      end else mp++;
    end
    @(negedge clk);
    pix_en = 1'b0;
  endtask

  task automatic t_defaults_small();
    line_len = 32; frame_lines = 20;
    sav_cfg = 0; eav_cfg = 0; vbi_start_cfg = 0; vbi_end_cfg = 0;
    do_reset();
    // R3 auto SAV 6, R4 auto EAV 30, R5 auto start 15, R6 auto end 4, R7 wrap
    walk(32*20 + 33, 32, 20, 6, 30, 15, 4);
  endtask

  task automatic t_hold_without_enable();
    // R2: no pix_en, position must not move
    int p0, l0;
    p0 = int'(pix_idx); l0 = int'(line_idx);
    repeat (5) @(posedge clk);
    #1;
    check("R2", "pix_idx held", int'(pix_idx), p0);
    check("R2", "line_idx held", int'(line_idx), l0);
  endtask

  task automatic t_explicit();
    line_len = 32; frame_lines = 20;
    sav_cfg = 4; eav_cfg = 20; vbi_start_cfg = 8; vbi_end_cfg = 12;
    do_reset();
    // R3 R4 R5 R6 direct values, R7 non-wrapping
    walk(32*20 + 5, 32, 20, 4, 20, 8, 12);
  endtask

  task automatic t_hd_line();
    line_len = 1650; frame_lines = 750;
    sav_cfg = 0; eav_cfg = 12'h5DC; vbi_start_cfg = 11'h2E9; vbi_end_cfg = 0;
    do_reset();
    // R3 derived 309, R4 direct 1500, R5 745, R6 derived 4
    walk(1650 + 2, 1650, 750, 309, 1500, 745, 4);
  endtask

  task automatic t_midframe_write();
    line_len = 32; frame_lines = 20;
    sav_cfg = 4; eav_cfg = 20; vbi_start_cfg = 8; vbi_end_cfg = 12;
    do_reset();
    walk(40, 32, 20, 4, 20, 8, 12);
    // R9: new values written mid-frame must wait for the frame wrap
    sav_cfg = 10; eav_cfg = 25; vbi_start_cfg = 2; vbi_end_cfg = 3;
    walk(32*20 - 40, 32, 20, 4, 20, 8, 12);
    walk(32*20, 32, 20, 10, 25, 2, 3);
  endtask

  task automatic edge_pulse(input bit frz, input int pos);
    @(negedge clk);
    freeze_en = frz; hs_edge_valid = 1'b1; hs_edge_pos = CW'(pos);
    @(negedge clk);
    hs_edge_valid = 1'b0;
    #1;
  endtask

  task automatic t_freeze();
    line_len = 32; frame_lines = 20;
    sav_cfg = 0; eav_cfg = 0; vbi_start_cfg = 0; vbi_end_cfg = 0;
    do_reset();
    #1;
    check("R7", "vbi on line 1", int'(vbi), 1);
    edge_pulse(1'b1, 7);
    check("R10", "frozen in vbi", int'(hs_trail_pos), 0);
    edge_pulse(1'b0, 9);
    check("R11", "update in vbi, freeze off", int'(hs_trail_pos), 9);
    walk(32*4, 32, 20, 6, 30, 15, 4);
    #1;
    check("R7", "vbi on line 5", int'(vbi), 0);
    edge_pulse(1'b1, 13);
    check("R11", "update outside vbi, freeze on", int'(hs_trail_pos), 13);
    freeze_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_defaults_small();
    t_hold_without_enable();
    t_explicit();
    t_hd_line();
    t_midframe_write();
    t_freeze();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule